// File: doc/BRIEF.md
# Banked Static Memory with Single-Block Activation

This block is a synchronous memory whose storage is divided into a parameterised number of equal sub-arrays (32 by default). Every address is split into three fields: a block field in the upper bits that picks one sub-array, a row field in the middle that picks a row inside it, and a column field in the lowest bits that picks a bit position inside that row. On each access, only the named sub-array is switched on. All the others stay idle, which keeps row-line and sense activity confined to one small array.

A chip-select input marks a cycle as an access, and a write-enable input chooses between a write and a read. A mode input sets the data port width. In narrow mode a single bit is written or read. In wide mode an aligned group of four bits is written or read. Each sub-array has a counter of the cycles in which it was enabled. The counters are brought out so that a testbench can confirm that each access touched exactly one sub-array. The sizes are parameters, so the array can be shrunk for fast simulation.

Top module: `banked_sram`

## Requirements
- R1: The address is split, from most to least significant, into block (log2 of the block count bits), row (ROW_BITS) and column (COL_BITS). Bit (block, row, col) is one storage location, shared by both port widths.
- R2: In a cycle with chip select high, exactly one sub-array is enabled: the one whose index equals the block field. With chip select low, none is enabled.
- R3: Each sub-array's activity counter, at bits [b*CNT_W +: CNT_W] of act_cnt, rises by one after every cycle in which that sub-array is enabled. It never changes otherwise and saturates at its all-ones value.
- R4: Read data is registered. A read request sampled at a rising edge shows its data on dout just after that edge, and the data stays there until the next read.
- R5: In narrow mode (wide_mode = 0), a write stores din[0] at the addressed bit and leaves every other bit unchanged. A read returns that bit on dout[0], with dout[3:1] = 0.
- R6: In wide mode (wide_mode = 1), the two lowest column bits are ignored. Data bit i maps to column {col[COL_BITS-1:2], 2'b00} + i, both when writing din and when reading dout.
- R7: A cycle with chip select low changes no storage bit, no counter and no output bit, whatever the other inputs are.
- R8: A write cycle leaves dout at its previous value.
- R9: Reset (rst_n low, asynchronous) clears all storage bits, all counters and dout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select; high marks an access |
| we | input | 1 | High for write, low for read |
| wide_mode | input | 1 | 0 = one-bit port, 1 = four-bit port |
| addr | input | ADDR_W | {block, row, column} address |
| din | input | 4 | Write data (bit 0 only in narrow mode) |
| dout | output | 4 | Registered read data |
| act_cnt | output | NUM_BLOCKS*CNT_W | Per-sub-array activity counters, block 0 in the low bits |

## Verification
The bench mixes narrow and wide accesses to the same bits. A field split or column alignment that was wrong would then show up as data seen at the wrong bit lane or in the wrong block. It writes with chip select low and reads the location back, so a design that let deselected cycles reach the storage, counters or output register fails. It drives one block's counter past its all-ones value, which catches a counter that wraps. It also checks that dout holds through write cycles, which catches an output register that loads on every access.

// File: rtl/banked_sram_pkg.sv
package banked_sram_pkg;
   // data port width in wide mode; the narrow mode uses lane 0 only
   localparam int unsigned IO_W = 4;

   typedef enum logic {
      MODE_X1 = 1'b0,
      MODE_X4 = 1'b1
   } io_mode_e;
endpackage

// File: rtl/bsr_block_decoder.sv
module bsr_block_decoder #(
   parameter int unsigned NUM_BLOCKS = 32,
   localparam int unsigned BLK_BITS = $clog2(NUM_BLOCKS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cs,
   input  logic [BLK_BITS-1:0]   blk,
   output logic [NUM_BLOCKS-1:0] blk_en
);
   for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_dec
      assign blk_en[i] = cs && (blk == BLK_BITS'(i));
   end

   // R2
   one_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs |-> ($countones(blk_en) == 1) && blk_en[blk]);
   // R2
   none_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |-> (blk_en == '0));
endmodule

// File: rtl/bsr_subarray.sv
module bsr_subarray #(
   parameter int unsigned ROW_BITS = 3,
   parameter int unsigned ROW_W    = 8,
   localparam int unsigned ROWS    = 1 << ROW_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                we,
   input  logic [ROW_BITS-1:0] row,
   input  logic [ROW_W-1:0]    wmask,
   input  logic [ROW_W-1:0]    wbits,
   output logic [ROW_W-1:0]    rd_row
);
   logic [ROWS-1:0][ROW_W-1:0] cells;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cells <= '0;
      end else if (en && we) begin
         cells[row] <= (cells[row] & ~wmask) | (wbits & wmask);
      end
   end

   assign rd_row = cells[row];

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(cells));
   // R5
   unmasked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && we) |=> ((cells[$past(row)] & ~$past(wmask))
                      == ($past(cells[row]) & ~$past(wmask))));
endmodule

// File: rtl/bsr_activity_counter.sv
module bsr_activity_counter #(
   parameter int unsigned CNT_W    = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] MAXV = '1;

   logic [CNT_W-1:0] cnt_next;

   if (SATURATE) begin : g_sat
      assign cnt_next = (cnt == MAXV) ? cnt : cnt + 1'b1;
   end else begin : g_wrap
      assign cnt_next = cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cnt <= '0;
      else if (en) cnt <= cnt_next;
   end

   // R3
   cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(cnt));
   // R3
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cnt != MAXV) |=> (cnt == $past(cnt) + 1'b1));
   // R3
   cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (SATURATE && en && cnt == MAXV) |=> (cnt == MAXV));
endmodule

// File: rtl/banked_sram.sv
module banked_sram
   import banked_sram_pkg::*;
#(
   parameter int unsigned NUM_BLOCKS   = 32,
   parameter int unsigned ROW_BITS     = 3,
   parameter int unsigned COL_BITS     = 3,
   parameter int unsigned CNT_W        = 16,
   parameter bit          CNT_SATURATE = 1'b1,
   localparam int unsigned BLK_BITS = $clog2(NUM_BLOCKS),
   localparam int unsigned ADDR_W   = BLK_BITS + ROW_BITS + COL_BITS
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cs,
   input  logic                        we,
   input  logic                        wide_mode,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [3:0]                  din,
   output logic [3:0]                  dout,
   output logic [NUM_BLOCKS*CNT_W-1:0] act_cnt
);
   localparam int unsigned ROW_W = 1 << COL_BITS;

   initial begin
      blocks_pow2_chk: assert (NUM_BLOCKS == (1 << BLK_BITS) && NUM_BLOCKS >= 2)
         else $error("NUM_BLOCKS must be a power of two, at least 2");
      col_bits_chk: assert (COL_BITS >= 2)
         else $error("COL_BITS must be at least 2 for the wide port");
      io_width_chk: assert (IO_W == 4)
         else $error("wide port is four bits");
   end

   // R1: address field split
   logic [BLK_BITS-1:0] blk_f;
   logic [ROW_BITS-1:0] row_f;
   logic [COL_BITS-1:0] col_f;
   logic [COL_BITS-1:0] base_f;
   io_mode_e            mode;

   assign blk_f  = addr[ADDR_W-1 -: BLK_BITS];
   assign row_f  = addr[COL_BITS +: ROW_BITS];
   assign col_f  = addr[COL_BITS-1:0];
   assign base_f = {col_f[COL_BITS-1:2], 2'b00};
   assign mode   = io_mode_e'(wide_mode);

   logic [NUM_BLOCKS-1:0] blk_en;

   bsr_block_decoder #(.NUM_BLOCKS(NUM_BLOCKS)) u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs     (cs),
      .blk    (blk_f),
      .blk_en (blk_en)
   );

   // write lane mask and data positioned in the row
   logic [ROW_W-1:0] wmask;
   logic [ROW_W-1:0] wbits;

   always_comb begin
      if (mode == MODE_X4) begin
         wmask = ROW_W'(4'hF) << base_f;
         wbits = {(ROW_W/4){din}};
      end else begin
         wmask = ROW_W'(1'b1) << col_f;
         wbits = {ROW_W{din[0]}};
      end
   end

   logic [ROW_W-1:0] rd_rows [NUM_BLOCKS];

   for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
      bsr_subarray #(.ROW_BITS(ROW_BITS), .ROW_W(ROW_W)) u_arr (
         .clk    (clk),
         .rst_n  (rst_n),
         .en     (blk_en[b]),
         .we     (we),
         .row    (row_f),
         .wmask  (wmask),
         .wbits  (wbits),
         .rd_row (rd_rows[b])
      );

      bsr_activity_counter #(.CNT_W(CNT_W), .SATURATE(CNT_SATURATE)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (blk_en[b]),
         .cnt   (act_cnt[b*CNT_W +: CNT_W])
      );
   end

   // read lane select
   logic [ROW_W-1:0] sel_row;
   logic [3:0]       rd_data;

   assign sel_row = rd_rows[blk_f];

   always_comb begin
      if (mode == MODE_X4) rd_data = sel_row[base_f +: 4];
      else                 rd_data = {3'b000, sel_row[col_f]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          dout <= '0;
      else if (cs && !we)  dout <= rd_data;
   end

   // R7
   desel_dout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |=> $stable(dout));
   // R8
   write_dout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && we) |=> $stable(dout));
   // R5
   narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && !we && !wide_mode) |=> (dout[3:1] == 3'b000));
endmodule

// File: tb/banked_sram_tb.sv
`timescale 1ns/1ps
module banked_sram_tb;
   localparam int unsigned NB    = 32;
   localparam int unsigned RB    = 3;
   localparam int unsigned CB    = 3;
   localparam int unsigned CW    = 8;
   localparam int unsigned BB    = $clog2(NB);
   localparam int unsigned AW    = BB + RB + CB;
   localparam int unsigned TOTAL = NB << (RB + CB);
   localparam int unsigned CMAX  = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n;
   logic cs, we, wide_mode;
   logic [AW-1:0] addr;
   logic [3:0] din;
   logic [3:0] dout;
   logic [NB*CW-1:0] act_cnt;

   always #2.5 clk = ~clk;

   banked_sram #(.NUM_BLOCKS(NB), .ROW_BITS(RB), .COL_BITS(CB), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .wide_mode(wide_mode),
      .addr(addr), .din(din), .dout(dout), .act_cnt(act_cnt)
   );

   int checks = 0;
   int errors = 0;
   logic mbits [TOTAL];
   int unsigned ecnt [NB];
   logic [3:0] exp_dout;

   function automatic int unsigned bit_idx(input logic [AW-1:0] a, input int unsigned lane,
                                           input logic wide);
      int unsigned blk = int'(a[AW-1 -: BB]);
      int unsigned row = int'(a[CB +: RB]);
      int unsigned col = int'(a[CB-1:0]);
      if (wide) col = (col & ~32'd3) + lane;
      return (blk << (RB + CB)) + (row << CB) + col;
   endfunction

   function automatic logic [3:0] model_read(input logic [AW-1:0] a, input logic wide);
      logic [3:0] r = 4'b0000;
      if (wide) begin
         for (int i = 0; i < 4; i++) r[i] = mbits[bit_idx(a, i, 1'b1)];
      end else begin
         r[0] = mbits[bit_idx(a, 0, 1'b0)];
      end
      return r;
   endfunction

   task automatic check_dout(input string tag);
      checks++;
      if (dout !== exp_dout) begin
         errors++;
         $display("FAIL %s dout actual=%h expected=%h", tag, dout, exp_dout);
      end
   endtask

   task automatic check_counters();
      for (int b = 0; b < NB; b++) begin
         checks++;
         if (act_cnt[b*CW +: CW] !== CW'(ecnt[b])) begin
            errors++;
            $display("FAIL R2 R3 block %0d counter actual=%0d expected=%0d",
                     b, act_cnt[b*CW +: CW], ecnt[b]);
         end
      end
   endtask

   // called at a negedge: drives, lets one edge pass, checks at next negedge
   task automatic op(input logic c, input logic w, input logic m,
                     input logic [AW-1:0] a, input logic [3:0] d);
      string tag;
      cs = c; we = w; wide_mode = m; addr = a; din = d;
      @(posedge clk);
      #1;
      if (c) begin
         int unsigned blk = int'(a[AW-1 -: BB]);
         if (ecnt[blk] < CMAX) ecnt[blk]++;
         if (w) begin
            if (m) for (int i = 0; i < 4; i++) mbits[bit_idx(a, i, 1'b1)] = d[i];
            else mbits[bit_idx(a, 0, 1'b0)] = d[0];
         end else begin
            exp_dout = model_read(a, m);
         end
      end
      @(negedge clk);
      if (!c)     tag = "R7";
      else if (w) tag = "R8";
      else if (m) tag = "R4 R6";
      else        tag = "R4 R5";
      check_dout(tag);
      check_counters();
   endtask

   function automatic logic [AW-1:0] mk(input int unsigned b, input int unsigned r,
                                        input int unsigned c);
      return {BB'(b), RB'(r), CB'(c)};
   endfunction

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < TOTAL; i++) mbits[i] = 1'b0;
      for (int b = 0; b < NB; b++) ecnt[b] = 0;
      exp_dout = 4'h0;
      rst_n = 1'b0; cs = 1'b0; we = 1'b0; wide_mode = 1'b0; addr = '0; din = '0;
      repeat (3) @(negedge clk);
      check_dout("R9");          // R9 reset output
      check_counters();          // R9 reset counters
      rst_n = 1'b1;
      @(negedge clk);

      // R9: storage cleared; R1 field split via narrow write, wide read
      op(1, 0, 1, mk(5, 2, 4), 4'h0);
      op(1, 1, 0, mk(5, 2, 7), 4'h1);
      op(1, 0, 1, mk(5, 2, 4), 4'h0);   // expect lane 3 set (R1, R6)
      op(1, 0, 0, mk(4, 2, 7), 4'h0);   // neighbouring block untouched (R1)
      op(1, 0, 0, mk(5, 3, 7), 4'h0);   // neighbouring row untouched (R1)

      // R6: low column bits ignored
      op(1, 1, 1, mk(9, 1, 7), 4'hA);
      op(1, 0, 1, mk(9, 1, 4), 4'h0);
      op(1, 0, 0, mk(9, 1, 5), 4'h0);   // narrow view of lane 1 (R5)
      op(1, 0, 1, mk(9, 1, 0), 4'h0);   // other group stays zero

      // R7: deselected write ignored; R8 dout held on write
      op(1, 0, 1, mk(9, 1, 5), 4'h0);
      op(0, 1, 1, mk(9, 1, 4), 4'h5);
      op(1, 1, 0, mk(9, 1, 0), 4'h1);
      op(1, 0, 1, mk(9, 1, 6), 4'h0);

      // R3: saturation of block 7 counter
      for (int i = 0; i < CMAX + 20; i++) op(1, 0, 0, mk(7, 0, 0), 4'h0);
      checks++;
      if (act_cnt[7*CW +: CW] !== CW'(CMAX)) begin
         errors++;
         $display("FAIL R3 saturation actual=%0d expected=%0d", act_cnt[7*CW +: CW], CMAX);
      end

      // random mix
      for (int n = 0; n < 3000; n++) begin
         logic c = ($urandom % 8) != 0;
         logic w = $urandom % 2;
         logic m = $urandom % 2;
         op(c, w, m, AW'($urandom), 4'($urandom));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule